// File: doc/BRIEF.md
# Sector-Erase Command Decoder with Polled Status

This block sits on the device side of an 8-bit parallel flash model. It watches the stream of decoded byte writes, each with a 16-bit low address, a sector field and a data byte. It recognises the six-write software sequence that requests a sector erase: two unlock writes, a setup write, two more unlock writes, and a final write that names the sector. When the sixth write is accepted, the block latches the sector number and runs an internal erase timer whose length is a parameter.

While the timer runs, the block raises `busy` and answers every read with a status byte instead of array data. Bit 7 reads as the complement of an erased byte's bit 7, so it reads 0. Bit 6 changes value on every read. Software can poll either bit to learn when the erase has finished. When the timer expires, reads again pass the array's data through unchanged. Any write that does not fit the expected pattern sends the decoder back to idle.

Top module: `flash_erase_seq`

## Requirements
- R1: The writes (low address 5555h, data AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then data 30h at any low address, start an erase. `busy` is high in the cycle after the clock edge that accepts the sixth write.
- R2: `busy` stays high for exactly ERASE_CYC clock cycles and then drops by itself.
- R3: `erase_sect` holds the value of `wr_sect` that was presented with the sixth write.
- R4: A write whose low address or data breaks the pattern at any step returns the decoder to idle, so completing the remaining writes afterwards starts no erase.
- R5: While `busy` is high, a read returns bit 7 = 0, the complement of the erased value 1.
- R6: While `busy` is high, bit 6 of the read value inverts on each successive read, and bits 5:0 read 0.
- R7: While `busy` is low, `rd_data` equals `arr_data`.
- R8: Writes made while `busy` is high are ignored. A complete sequence written during an erase neither extends `busy` nor changes `erase_sect`.
- R9: After reset, `busy` is 0 and reads pass `arr_data` through.
- R10: Only the low 16 address bits are compared on writes one to five. The value of `wr_sect` on those writes has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe, one cycle per write |
| wr_addr | input | 16 | Low address of the write |
| wr_sect | input | SECT_W | Sector field of the write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| arr_data | input | 8 | Array byte at the read address |
| rd_data | output | 8 | Read result: status while busy, array data otherwise |
| busy | output | 1 | Internal erase running |
| erase_sect | output | SECT_W | Sector named by the last accepted sequence |

## Verification
A step counter that has drifted shows up as an erase that starts from an incomplete or corrupted sequence, or as one that never starts. Either case is visible on `busy` one cycle after the sixth write. An error in the erase counter changes the length of the `busy` window, which the bench measures cycle by cycle against ERASE_CYC. A stuck or double-stepping toggle register, or the wrong source chosen for read data, corrupts the very next read, so every read in the bench is compared at once.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   localparam logic [15:0] UNLOCK_LO = 16'h5555;
   localparam logic [15:0] UNLOCK_HI = 16'h2AAA;
   localparam int          N_STEPS   = 6;
   localparam logic        ERASED_B7 = 1'b1;

   typedef logic [2:0] step_t;

   localparam step_t LAST_STEP = step_t'(N_STEPS - 1);

   function automatic logic [15:0] key_addr(input step_t s);
      case (s)
         3'd1, 3'd4: key_addr = UNLOCK_HI;
         default:    key_addr = UNLOCK_LO;
      endcase
   endfunction

   function automatic logic [7:0] key_data(input step_t s);
      case (s)
         3'd0, 3'd3: key_data = 8'hAA;
         3'd1, 3'd4: key_data = 8'h55;
         3'd2:       key_data = 8'h80;
         default:    key_data = 8'h30;
      endcase
   endfunction

   function automatic logic addr_checked(input step_t s);
      addr_checked = (s != LAST_STEP);
   endfunction

endpackage

// File: rtl/flash_unlock_fsm.sv
module flash_unlock_fsm
   import flash_seq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wr_addr,
   input  logic [7:0]  wr_data,
   input  logic        busy,
   output logic        start
);

   step_t step;
   logic  hit;

   always_comb begin
      hit   = (wr_data == key_data(step)) &&
              (!addr_checked(step) || (wr_addr == key_addr(step)));
      start = wr_en && !busy && hit && (step == LAST_STEP);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         step <= '0;
      else if (wr_en && !busy)
         step <= (hit && step != LAST_STEP) ? step + 3'd1 : '0;
   end

   // R4
   bad_data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy && step != 3'd0 && wr_data != key_data(step)) |=> (step == 3'd0));

endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
   parameter int ERASE_CYC = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int CW = (ERASE_CYC > 2) ? $clog2(ERASE_CYC) : 1;

   logic [CW-1:0] cnt;

   generate
      if (ERASE_CYC < 2) begin : g_bad_len
         $error("ERASE_CYC must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= CW'(ERASE_CYC - 1);
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   // R2
   end_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(cnt) == '0));

endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
   import flash_seq_pkg::*;
#(
   parameter bit RD_PIPE = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_en,
   input  logic       busy,
   input  logic [7:0] arr_data,
   output logic [7:0] rd_data
);

   logic       tog;
   logic [7:0] status;

   always_comb
      status = busy ? {~ERASED_B7, tog, 6'b0} : arr_data;

   always_ff @(posedge clk) begin
      if (!rst_n)            tog <= 1'b0;
      else if (rd_en && busy) tog <= ~tog;
   end

   generate
      if (RD_PIPE) begin : g_reg
         logic [7:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n)    rd_q <= '0;
            else if (rd_en) rd_q <= status;
         end
         assign rd_data = rd_q;
      end else begin : g_comb
         assign rd_data = status;
      end
   endgenerate

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
   parameter int SECT_W    = 8,
   parameter int ERASE_CYC = 40,
   parameter bit RD_PIPE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [15:0]       wr_addr,
   input  logic [SECT_W-1:0] wr_sect,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   input  logic [7:0]        arr_data,
   output logic [7:0]        rd_data,
   output logic              busy,
   output logic [SECT_W-1:0] erase_sect
);

   generate
      if (SECT_W < 1) begin : g_bad_sect
         $error("SECT_W must be at least 1");
      end
   endgenerate

   logic seq_start;

   flash_unlock_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .busy    (busy),
      .start   (seq_start)
   );

   flash_erase_timer #(.ERASE_CYC(ERASE_CYC)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (seq_start),
      .busy  (busy)
   );

   flash_status_mux #(.RD_PIPE(RD_PIPE)) u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .busy     (busy),
      .arr_data (arr_data),
      .rd_data  (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        erase_sect <= '0;
      else if (seq_start) erase_sect <= wr_sect;
   end

   // R1
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |=> busy);

   // R3
   sect_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (erase_sect == $past(wr_sect)));

   // R8
   busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en) |=> (erase_sect == $past(erase_sect)));

   // R5
   poll_b7_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!RD_PIPE && busy) |-> (rd_data[7] == 1'b0));

endmodule

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;

   localparam int SW = 8;
   localparam int EC = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [15:0]   wr_addr = '0;
   logic [SW-1:0] wr_sect = '0;
   logic [7:0]    wr_data = '0, arr_data = '0;
   logic [7:0]    rd_data;
   logic          busy;
   logic [SW-1:0] erase_sect;

   always #2 clk = ~clk;

   flash_erase_seq #(.SECT_W(SW), .ERASE_CYC(EC), .RD_PIPE(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_sect(wr_sect), .wr_data(wr_data), .rd_en(rd_en),
      .arr_data(arr_data), .rd_data(rd_data), .busy(busy),
      .erase_sect(erase_sect)
   );

   int n_chk = 0, n_bad = 0;
   bit exp_tog = 1'b0;
   int run = 0, last_run = 0;
   bit done = 1'b0;

   always @(negedge clk) begin
      if (busy) run++;
      else if (run != 0) begin last_run = run; run = 0; end
   end

   function automatic logic [15:0] exp_addr(input int i);
      return (i == 1 || i == 4) ? 16'h2AAA : 16'h5555;
   endfunction

   function automatic logic [7:0] exp_data(input int i);
      case (i)
         0, 3: return 8'hAA;
         1, 4: return 8'h55;
         2:    return 8'h80;
         default: return 8'h30;
      endcase
   endfunction

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [SW-1:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_sect = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(output logic [7:0] v);
      @(negedge clk);
      rd_en = 1'b1;
      #1 v = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // bad_k < 0: clean sequence; mode 0 corrupts the address, mode 1 the data
   task automatic run_seq(input logic [SW-1:0] sect, input int bad_k, input int mode);
      for (int i = 0; i < 6; i++) begin
         logic [15:0] a;
         logic [7:0]  d;
         logic [SW-1:0] s;
         a = (i == 5) ? 16'($urandom) : exp_addr(i);
         d = exp_data(i);
         s = (i == 5) ? sect : SW'($urandom);
         if (i == bad_k) begin
            if (mode == 0 && i != 5) a = a ^ 16'h0100;
            else d = d ^ (8'($urandom % 255) + 8'd1);
         end
         wr(a, s, d);
      end
   endtask

   task automatic busy_read();
      logic [7:0] v;
      rd(v);
      chk("R5 b7", {31'd0, v[7]}, 32'd0);
      chk("R6 b6", {31'd0, v[6]}, {31'd0, exp_tog});
      chk("R6 low", {26'd0, v[5:0]}, 32'd0);
      exp_tog = ~exp_tog;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      @(negedge clk);
      chk("R2 length", last_run, EC);
   endtask

   task automatic idle_read();
      logic [7:0] v;
      @(negedge clk);
      arr_data = 8'($urandom);
      rd(v);
      chk("R7 pass", {24'd0, v}, {24'd0, arr_data});
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      arr_data = 8'hA5;
      repeat (3) @(negedge clk);
      #1;
      chk("R9 busy", {31'd0, busy}, 32'd0);
      chk("R9 rd", {24'd0, rd_data}, 32'hA5);
      rst_n = 1'b1;

      // directed: full sequence, random sector bits on writes 1-5 (R10)
      run_seq(8'h3C, -1, 0);
      chk("R1 R10 busy", {31'd0, busy}, 32'd1);
      chk("R3 sect", {24'd0, erase_sect}, 32'h3C);
      for (int i = 0; i < 4; i++) busy_read();
      // R8: complete sequence written during the erase
      run_seq(8'h11, -1, 0);
      chk("R8 sect", {24'd0, erase_sect}, 32'h3C);
      wait_idle();
      repeat (3) @(negedge clk);
      chk("R8 no restart", {31'd0, busy}, 32'd0);
      idle_read();

      // R4: break each step by address and by data
      for (int k = 0; k < 6; k++) begin
         for (int m = 0; m < 2; m++) begin
            run_seq(8'h5A, k, m);
            @(negedge clk);
            chk("R4 no start", {31'd0, busy}, 32'd0);
         end
      end
      idle_read();

      // random mix
      for (int it = 0; it < 30; it++) begin
         int k;
         logic [SW-1:0] s;
         k = int'($urandom % 8);
         s = SW'($urandom);
         if (k < 6) begin
            run_seq(s, k, int'($urandom % 2));
            chk("R4 rnd", {31'd0, busy}, 32'd0);
            idle_read();
         end else begin
            run_seq(s, -1, 0);
            chk("R1 rnd", {31'd0, busy}, 32'd1);
            chk("R3 rnd", {24'd0, erase_sect}, {24'd0, s});
            for (int j = 0; j < 1 + int'($urandom % 3); j++) busy_read();
            wait_idle();
            idle_read();
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule